// File: doc/BRIEF.md
# Message Ring Pointer Unit

This block keeps the producer (PUT) and consumer (GET) pointers of one direction of a message ring shared between a host and an embedded controller. The ring holds eight slots of sixteen bytes each, and each slot carries one packet of four 32-bit words: process id, message code, first data word, second data word. Pointers are one bit wider than the slot index, so that a full ring can be told apart from an empty one. The producer writes all four words of a packet first and only then advances PUT. The consumer advances GET after it has read the packet.

The controller publishes a ring descriptor word. Its low half is the byte base of the ring in the shared data memory and its high half is the ring size. The word reads as zero until the controller has set the ring up. From the base and the active pointer the block forms the byte address of the current slot.

A parameter selects the direction. For host-to-controller the host is the producer, so the slot address follows PUT. For controller-to-host the host is the consumer, so the slot address follows GET. Moving packet words and arbitrating the memory are left to other logic.

Top module: `mbox_ring`

## Requirements
- R1: After reset both pointers, the descriptor word and the error flag are zero, `empty` is 1 and `full` is 0.
- R2: `empty` is 1 exactly when GET equals PUT.
- R3: `full` is 1 exactly when GET equals PUT with bit 3 inverted (PUT XOR 8).
- R4: A write to PUT while the ring is not full loads the written value, and the new value is visible on the cycle after the write.
- R5: A write to PUT while `full` is 1 leaves PUT unchanged and sets the error flag.
- R6: A write to GET while `empty` is 1 leaves GET unchanged and sets the error flag. A write to GET while the ring is not empty loads the value.
- R7: The error flag stays at 1 once set and is cleared only by reset.
- R8: A descriptor write stores the word. `ring_base` shows bits 15:0, `ring_size` shows bits 31:16, and `cfg_ready` is 1 when the word is nonzero.
- R9: `slot_addr` equals (pointer bits 2:0 shifted left by 4) plus `ring_base`, truncated to 16 bits. The pointer is PUT when `H2C` is 1 and GET when `H2C` is 0.
- R10: Pointers are 4 bits and wrap modulo 16, so a producer stepping from 15 to 0 stays consistent with the full and empty rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_wdata | input | 32 | Descriptor word: base in bits 15:0, size in bits 31:16 |
| put_we | input | 1 | PUT write strobe |
| put_wdata | input | 4 | New PUT value |
| get_we | input | 1 | GET write strobe |
| get_wdata | input | 4 | New GET value |
| put_ptr | output | 4 | Current PUT |
| get_ptr | output | 4 | Current GET |
| cfg_word | output | 32 | Stored descriptor word |
| ring_base | output | 16 | Ring byte base |
| ring_size | output | 16 | Ring size field |
| cfg_ready | output | 1 | Descriptor is nonzero |
| full | output | 1 | Ring full |
| empty | output | 1 | Ring empty |
| slot_addr | output | 16 | Byte address of the active slot |
| ring_err | output | 1 | Sticky rejected-write flag |

## Verification
Pointer, descriptor and error writes are registered, so each one shows on the outputs one clock edge after the strobe. `full`, `empty`, `slot_addr` and the descriptor fields are combinational from those registers, so they change on the same edge as the pointer they depend on. The bench drives a strobe at a falling edge, drops it at the next falling edge, and checks all results then, one rising edge later. A second instance built for the controller-to-host direction shares the same stimulus, so the bench can confirm that its slot address follows GET.

// File: rtl/mbox_ring.sv
module mbox_ring #(
  parameter bit H2C        = 1'b1,
  parameter int SLOT_LOG2  = 3,
  parameter int BYTES_LOG2 = 4,
  parameter int ADDR_W     = 16,
  parameter int CFG_W      = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [CFG_W-1:0]                  cfg_wdata,
  input  logic                              put_we,
  input  logic [SLOT_LOG2:0]                put_wdata,
  input  logic                              get_we,
  input  logic [SLOT_LOG2:0]                get_wdata,
  output logic [SLOT_LOG2:0]                put_ptr,
  output logic [SLOT_LOG2:0]                get_ptr,
  output logic [CFG_W-1:0]                  cfg_word,
  output logic [ADDR_W-1:0]                 ring_base,
  output logic [CFG_W-ADDR_W-1:0]           ring_size,
  output logic                              cfg_ready,
  output logic                              full,
  output logic                              empty,
  output logic [ADDR_W-1:0]                 slot_addr,
  output logic                              ring_err
);
  localparam int PTR_W = SLOT_LOG2 + 1;
  localparam logic [PTR_W-1:0] WRAP_BIT = PTR_W'(1) << SLOT_LOG2;

  logic             put_ok, get_ok, bad_wr;
  logic [PTR_W-1:0] act_ptr;

  assign empty  = (get_ptr == put_ptr);
  assign full   = (get_ptr == (put_ptr ^ WRAP_BIT));
  assign put_ok = put_we && !full;
  assign get_ok = get_we && !empty;
  assign bad_wr = (put_we && full) || (get_we && empty);

  assign ring_base = cfg_word[ADDR_W-1:0];
  assign ring_size = cfg_word[CFG_W-1:ADDR_W];
  assign cfg_ready = |cfg_word;

  generate
    if (H2C) begin : g_prod
      assign act_ptr = put_ptr;
    end else begin : g_cons
      assign act_ptr = get_ptr;
    end
  endgenerate

  assign slot_addr = ring_base +
    ADDR_W'({act_ptr[SLOT_LOG2-1:0], {BYTES_LOG2{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      put_ptr  <= '0;
      get_ptr  <= '0;
      cfg_word <= '0;
      ring_err <= 1'b0;
    end else begin
      if (put_ok) put_ptr  <= put_wdata;
      if (get_ok) get_ptr  <= get_wdata;
      if (cfg_we) cfg_word <= cfg_wdata;
      if (bad_wr) ring_err <= 1'b1;
    end
  end
endmodule

// File: rtl/mbox_ring_chk.sv
module mbox_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic        put_we,
  input logic [3:0]  put_wdata,
  input logic        get_we,
  input logic [3:0]  get_wdata,
  input logic [3:0]  put_ptr,
  input logic [3:0]  get_ptr,
  input logic [15:0] ring_base,
  input logic        full,
  input logic        empty,
  input logic        ring_err
);
  // R4
  put_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put_we && !full) |=> (put_ptr == $past(put_wdata)));
  // R5
  put_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put_we && full) |=> ($stable(put_ptr) && ring_err));
  // R6
  get_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (get_we && empty) |=> ($stable(get_ptr) && ring_err));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_err |=> ring_err);
  // R8
  cfg_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (ring_base == $past(cfg_wdata[15:0])));
  // R2
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

bind mbox_ring mbox_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .put_we(put_we), .put_wdata(put_wdata), .get_we(get_we),
  .get_wdata(get_wdata), .put_ptr(put_ptr), .get_ptr(get_ptr),
  .ring_base(ring_base), .full(full), .empty(empty), .ring_err(ring_err)
);

// File: tb/sim_mbox_ring.sv
module sim_mbox_ring;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        put_we = 1'b0;
  logic [3:0]  put_wdata = '0;
  logic        get_we = 1'b0;
  logic [3:0]  get_wdata = '0;
  logic [3:0]  put_ptr, get_ptr, put_ptr1, get_ptr1;
  logic [31:0] cfg_word, cfg_word1;
  logic [15:0] ring_base, ring_size, slot_addr, ring_base1, ring_size1, slot_addr1;
  logic        cfg_ready, full, empty, ring_err, cfg_ready1, full1, empty1, ring_err1;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mbox_ring #(.H2C(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .put_we(put_we), .put_wdata(put_wdata), .get_we(get_we), .get_wdata(get_wdata),
    .put_ptr(put_ptr), .get_ptr(get_ptr), .cfg_word(cfg_word), .ring_base(ring_base),
    .ring_size(ring_size), .cfg_ready(cfg_ready), .full(full), .empty(empty),
    .slot_addr(slot_addr), .ring_err(ring_err));

  mbox_ring #(.H2C(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .put_we(put_we), .put_wdata(put_wdata), .get_we(get_we), .get_wdata(get_wdata),
    .put_ptr(put_ptr1), .get_ptr(get_ptr1), .cfg_word(cfg_word1), .ring_base(ring_base1),
    .ring_size(ring_size1), .cfg_ready(cfg_ready1), .full(full1), .empty(empty1),
    .slot_addr(slot_addr1), .ring_err(ring_err1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_put(input logic [3:0] v);
    @(negedge clk); put_we = 1'b1; put_wdata = v;
    @(negedge clk); put_we = 1'b0;
  endtask

  task automatic wr_get(input logic [3:0] v);
    @(negedge clk); get_we = 1'b1; get_wdata = v;
    @(negedge clk); get_we = 1'b0;
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 put", 32'(put_ptr), 0);
    check("R1 get", 32'(get_ptr), 0);
    check("R1 cfg", cfg_word, 0);
    check("R1 ready", 32'(cfg_ready), 0);
    check("R1 err", 32'(ring_err), 0);
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
  endtask

  task automatic t_cfg;
    wr_cfg(32'h0008_0100);
    check("R8 base", 32'(ring_base), 32'h100);
    check("R8 size", 32'(ring_size), 8);
    check("R8 ready", 32'(cfg_ready), 1);
    check("R9 slot0", 32'(slot_addr), 32'h100);
  endtask

  task automatic t_fill;
    for (int i = 1; i <= 8; i++) begin
      wr_put(4'(i));
      check("R4 put", 32'(put_ptr), i);
      check("R9 h2c slot", 32'(slot_addr), 32'h100 + ((i % 8) * 16));
      check("R9 c2h slot", 32'(slot_addr1), 32'h100);
      check("R2 empty", 32'(empty), 0);
      check("R3 full", 32'(full), (i == 8) ? 1 : 0);
    end
    check("R7 err clean", 32'(ring_err), 0);
  endtask

  task automatic t_put_full;
    wr_put(4'd9);
    check("R5 put held", 32'(put_ptr), 8);
    check("R5 err", 32'(ring_err), 1);
    check("R3 still full", 32'(full), 1);
  endtask

  task automatic t_drain;
    for (int i = 1; i <= 8; i++) begin
      wr_get(4'(i));
      check("R6 get", 32'(get_ptr), i);
      check("R9 c2h slot", 32'(slot_addr1), 32'h100 + ((i % 8) * 16));
      check("R3 full", 32'(full), 0);
      check("R2 empty", 32'(empty), (i == 8) ? 1 : 0);
    end
  endtask

  task automatic t_get_empty;
    wr_get(4'd9);
    check("R6 get held", 32'(get_ptr), 8);
    check("R6 empty", 32'(empty), 1);
    check("R7 err stays", 32'(ring_err), 1);
  endtask

  task automatic t_wrap;
    for (int i = 9; i <= 16; i++) wr_put(4'(i % 16));
    check("R10 put wrap", 32'(put_ptr), 0);
    check("R10 full at wrap", 32'(full), 1);
    check("R9 slot wrap", 32'(slot_addr), 32'h100);
    for (int i = 9; i <= 16; i++) wr_get(4'(i % 16));
    check("R10 get wrap", 32'(get_ptr), 0);
    check("R10 empty at wrap", 32'(empty), 1);
  endtask

  task automatic t_rebase;
    wr_cfg(32'h0010_FFF0);
    check("R8 base2", 32'(ring_base), 32'hFFF0);
    check("R8 size2", 32'(ring_size), 16);
    wr_put(4'd3);
    check("R9 slot trunc", 32'(slot_addr), 32'h0020);
    check("R7 err final", 32'(ring_err), 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_fill();
    t_put_full();
    t_drain();
    t_get_empty();
    t_wrap();
    t_rebase();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule